// File: doc/BRIEF.md
# Staged Memory Access Sequencer

This block sits between a processor datapath and a word-addressable synchronous memory. The datapath never drives the memory address or data lines itself. Every access goes through two staging registers: an address stage register that drives the memory address bus, and a data stage register that drives the memory write bus and also returns load results. A requester raises a load or a store command. The sequencer then runs a fixed order of register writes and memory strobes, and it ends each access with a one-cycle done pulse.

A load writes the address stage first. It then issues a read strobe. The memory returns the word one cycle later, and that word is captured into the data stage. A store runs in a different order. It writes the data stage first, then the address stage, and only after both does it issue the write strobe. Each address selects one whole word, so a single memory access moves a full word. The default configuration has a 16-bit address space and 16-bit words.

Top module: `mem_stage_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, mem_rd_o and mem_wr_o are low, and mem_addr_o and rdata_o are zero.
- R2: A load is accepted on a clock edge where busy_o is low and req_load_i is high. In the next cycle, mem_rd_o is high for exactly one cycle and mem_addr_o equals the addr_i value sampled at acceptance.
- R3: The word returned by the memory one cycle after the read strobe is captured whole into the data stage. In the cycle after that capture, rdata_o shows it, and it stays there until the next accepted access.
- R4: A store writes wdata_i into the data stage at acceptance, so mem_wdata_o shows it in the next cycle. The address stage is then loaded from addr_i, which the requester holds for one cycle after acceptance. Two cycles after acceptance, mem_wr_o is high for one cycle with mem_addr_o and mem_wdata_o carrying the address and the word.
- R5: done_o is a single-cycle pulse. For a store it comes in the cycle after the write strobe. For a load it comes in the cycle after the data stage update, which is three cycles after acceptance.
- R6: busy_o is high from the cycle after acceptance through the done cycle. Commands presented while busy_o is high cause no strobe and do not change the staging registers.
- R7: mem_rd_o and mem_wr_o are never high in the same cycle.
- R8: When req_load_i and req_store_i are both high at acceptance, the load is performed and the store is discarded.
- R9: While idle with no command, changes on addr_i and wdata_i do not reach mem_addr_o or mem_wdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_load_i | input | 1 | Load command |
| req_store_i | input | 1 | Store command |
| addr_i | input | ADDR_W | Target word address |
| wdata_i | input | DATA_W | Store data word |
| rdata_o | output | DATA_W | Load result (data stage contents) |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | ADDR_W | Memory address, driven by the address stage |
| mem_wdata_o | output | DATA_W | Memory write data, driven by the data stage |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | DATA_W | Memory read data, valid one cycle after the read strobe |

## Verification
Some rules are checked by the assertions on every cycle. These are: the two strobes never overlap, done never lasts two cycles, each write strobe is followed by done, each read strobe is followed by a capture and then by done, and the memory buses stay stable while the block is idle without a command. Other behaviour can only be shown by the bench scenarios. Those scenarios sweep every address of a small memory with stores and then loads. They check the staging order cycle by cycle and compare each returned word with the expected one. They also show that commands presented mid-access leave memory untouched, and that a simultaneous load and store resolves to the load.

// File: rtl/mem_seq_pkg.sv
package mem_seq_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE   = 3'd0,
    SEQ_LD_RD  = 3'd1,
    SEQ_LD_CAP = 3'd2,
    SEQ_ST_MAR = 3'd3,
    SEQ_ST_WR  = 3'd4,
    SEQ_DONE   = 3'd5
  } seq_state_e;

  typedef enum logic {
    MDR_FROM_REQ = 1'b0,
    MDR_FROM_MEM = 1'b1
  } mdr_src_e;
endpackage

// File: rtl/mem_stage_reg.sv
module mem_stage_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/mem_seq_fsm.sv
module mem_seq_fsm
  import mem_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_load_i,
  input  logic     req_store_i,
  output logic     mar_ld_o,
  output logic     mdr_ld_o,
  output mdr_src_e mdr_src_o,
  output logic     mem_rd_o,
  output logic     mem_wr_o,
  output logic     busy_o,
  output logic     done_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    mar_ld_o  = 1'b0;
    mdr_ld_o  = 1'b0;
    mdr_src_o = MDR_FROM_REQ;
    mem_rd_o  = 1'b0;
    mem_wr_o  = 1'b0;
    done_o    = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (req_load_i) begin           // load wins a tie
          mar_ld_o = 1'b1;
          state_d  = SEQ_LD_RD;
        end else if (req_store_i) begin
          mdr_ld_o = 1'b1;
          state_d  = SEQ_ST_MAR;
        end
      end
      SEQ_LD_RD: begin
        mem_rd_o = 1'b1;
        state_d  = SEQ_LD_CAP;
      end
      SEQ_LD_CAP: begin
        mdr_ld_o  = 1'b1;
        mdr_src_o = MDR_FROM_MEM;
        state_d   = SEQ_DONE;
      end
      SEQ_ST_MAR: begin
        mar_ld_o = 1'b1;
        state_d  = SEQ_ST_WR;
      end
      SEQ_ST_WR: begin
        mem_wr_o = 1'b1;
        state_d  = SEQ_DONE;
      end
      SEQ_DONE: begin
        done_o  = 1'b1;
        state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o = (state_q != SEQ_IDLE);

  assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_wr_then_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> done_o);
  assert_rd_then_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> (mdr_ld_o && mdr_src_o == MDR_FROM_MEM));
  assert_capture_then_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdr_ld_o && mdr_src_o == MDR_FROM_MEM) |=> done_o);
  assert_busy_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_load_i || req_store_i));
endmodule

// File: rtl/mem_stage_ctrl.sv
module mem_stage_ctrl
  import mem_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_load_i,
  input  logic              req_store_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic              mar_ld, mdr_ld;
  mdr_src_e          mdr_src;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] mdr_q, mdr_d;

  mem_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_load_i (req_load_i),
    .req_store_i(req_store_i),
    .mar_ld_o   (mar_ld),
    .mdr_ld_o   (mdr_ld),
    .mdr_src_o  (mdr_src),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  assign mdr_d = (mdr_src == MDR_FROM_MEM) ? mem_rdata_i : wdata_i;

  mem_stage_reg #(.W(ADDR_W)) u_mar (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(mar_ld), .d_i(addr_i), .q_o(mar_q)
  );

  mem_stage_reg #(.W(DATA_W)) u_mdr (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(mdr_ld), .d_i(mdr_d), .q_o(mdr_q)
  );

  // memory sees only the staging registers
  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mdr_q;
  assign rdata_o     = mdr_q;

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !req_load_i && !req_store_i) |=> ($stable(mem_addr_o) && $stable(mem_wdata_o)));
  assert_busy_ignore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o) |=> ($stable(mem_addr_o) && $stable(rdata_o)));
  assert_wr_addr_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> ($stable(mem_addr_o) && $stable(mem_wdata_o)));
endmodule

// File: tb/mem_stage_ctrl_bench.sv
module mem_stage_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_load = 1'b0, req_store = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic busy, done, mem_rd, mem_wr;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_mem [DEPTH];
  logic [DW-1:0] ram [DEPTH];
  int wr_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_stage_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_mem_stage_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_load_i(req_load), .req_store_i(req_store),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy), .done_o(done),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rd_o(mem_rd),
    .mem_wr_o(mem_wr), .mem_rdata_i(mem_rdata)
  );

  // one-cycle read latency memory
  always @(posedge clk) begin
    if (mem_wr) begin
      ram[mem_addr] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
    if (mem_rd) mem_rdata <= ram[mem_addr];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int pass);
    if (pass == 1 && a == 0)         return '0;
    if (pass == 1 && a == DEPTH - 1) return '1;
    return DW'((a * 16'h3B1 + 16'hA5C3) ^ (pass * 16'h5A5A));
  endfunction

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_store = 1'b1; addr = a; wdata = d;
    @(negedge clk);                       // accepted; data stage written
    req_store = 1'b0; wdata = ~d;
    check(busy == 1'b1, "R6 busy after store accept", {31'd0, busy}, 1);
    check(mem_wdata == d, "R4 data stage first", {16'd0, mem_wdata}, {16'd0, d});
    check(mem_wr == 1'b0, "R4 no early write", {31'd0, mem_wr}, 0);
    @(negedge clk);                       // address stage loaded
    addr = ~a;
    check(mem_wr == 1'b1 && mem_rd == 1'b0, "R4 write strobe", {30'd0, mem_wr, mem_rd}, 2);
    check(mem_addr == a, "R4 write address", {26'd0, mem_addr}, {26'd0, a});
    check(mem_wdata == d, "R4 write data", {16'd0, mem_wdata}, {16'd0, d});
    check(done == 1'b0, "R5 no done during strobe", {31'd0, done}, 0);
    @(negedge clk);
    check(done == 1'b1 && mem_wr == 1'b0, "R5 store done", {30'd0, done, mem_wr}, 2);
    check(busy == 1'b1, "R6 busy in done cycle", {31'd0, busy}, 1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R5 done single pulse", {30'd0, done, busy}, 0);
    exp_mem[a] = d;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input bit intrude, input bit both);
    int wr_before;
    wr_before = wr_count;
    @(negedge clk);
    req_load = 1'b1; addr = a;
    if (both) begin req_store = 1'b1; wdata = 16'hDEAD; end
    @(negedge clk);                       // accepted; read strobe now
    req_load = 1'b0; req_store = 1'b0;
    if (intrude) begin req_store = 1'b1; req_load = 1'b1; addr = ~a; wdata = 16'hBEEF; end
    check(mem_rd == 1'b1 && mem_wr == 1'b0, both ? "R8 tie resolves to read" : "R2 read strobe",
          {30'd0, mem_rd, mem_wr}, 2);
    check(mem_addr == a, "R2 read address", {26'd0, mem_addr}, {26'd0, a});
    check(busy == 1'b1, "R6 busy during load", {31'd0, busy}, 1);
    @(negedge clk);
    check(mem_rd == 1'b0 && done == 1'b0, "R2 read strobe one cycle", {30'd0, mem_rd, done}, 0);
    @(negedge clk);
    req_load = 1'b0; req_store = 1'b0;
    check(done == 1'b1, "R5 load done", {31'd0, done}, 1);
    check(rdata == exp_mem[a], "R3 load data", {16'd0, rdata}, {16'd0, exp_mem[a]});
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R5 load done single pulse", {30'd0, done, busy}, 0);
    check(rdata == exp_mem[a], "R3 data held", {16'd0, rdata}, {16'd0, exp_mem[a]});
    if (intrude || both) begin
      check(wr_count == wr_before, both ? "R8 store discarded" : "R6 busy command ignored",
            wr_count, wr_before);
      check(mem_addr == a, "R6 address stage untouched", {26'd0, mem_addr}, {26'd0, a});
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (mem_rd && mem_wr) begin
        errors++;
        $display("FAIL R7 strobes overlap actual=11 expected=not both");
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    check(busy == 0 && done == 0 && mem_rd == 0 && mem_wr == 0, "R1 reset controls",
          {28'd0, busy, done, mem_rd, mem_wr}, 0);
    check(mem_addr == '0 && rdata == '0, "R1 reset staging", {10'd0, mem_addr, rdata}, 0);
    rst_n = 1'b1;

    // R9: idle input changes do not reach memory buses
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      addr = AW'(i * 13 + 5); wdata = DW'(i * 16'h1111 + 3);
      @(negedge clk);
      check(mem_addr == '0 && mem_wdata == '0 && !mem_rd && !mem_wr, "R9 idle isolation",
            {10'd0, mem_addr, mem_wdata}, 0);
    end

    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < DEPTH; a++) do_store(AW'(a), pat(a, pass));
      for (int a = 0; a < DEPTH; a++) do_load(AW'(a), (a % 3) == 1, (a % 7) == 2);
    end

    // R9 after traffic: idle isolation holds the last staged values
    @(negedge clk);
    begin
      logic [AW-1:0] ha;
      logic [DW-1:0] hd;
      ha = mem_addr; hd = mem_wdata;
      addr = ~ha; wdata = ~hd;
      @(negedge clk);
      @(negedge clk);
      check(mem_addr == ha && mem_wdata == hd, "R9 idle hold after traffic",
            {10'd0, mem_addr, mem_wdata}, {10'd0, ha, hd});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule